// File: doc/BRIEF.md
# Sync-Aware Received Pattern Capture

This block takes a 32-bit snapshot of a serial receive stream and presents it as four byte-wide registers on a simple read port. It keeps a running history of the received bits, one shift for each bit the receiver marks as valid. A capture can be triggered by software through a control bit or by hardware through a pin. When the receiver is out of sync, the snapshot is the raw history. When it is in sync, the snapshot is the reference word that the pattern detector has locked to. Because of this, line errors never show up in a snapshot taken while locked.

The pattern detector is outside this block. It supplies the sync flag and the locked 32-bit word. The locked word has no fixed phase, so any rotation of the repeating pattern is an acceptable snapshot.

Capture is controlled by a two-state machine. In `LS_IDLE` the block waits for the request line, which is the OR of the control bit and the pin. The transition `IDLE->HELD` fires when the request is high and takes the snapshot. The block stays in `LS_HELD` while the request stays high. The transition `HELD->IDLE` fires when the request drops, which arms the next capture.

Top module: `pattern_snapshot`

## Requirements
- R1: Each cycle with `rx_en` high shifts the history left by one, and `rx_bit` enters at bit 0. With `rx_en` low, the history holds its value.
- R2: A capture while `in_sync` is 0 stores the history as it stood before that cycle. A bit accepted in the capture cycle itself is not included.
- R3: A capture while `in_sync` is 1 stores `lock_pat`. Received data, including errored bits, has no effect on that snapshot.
- R4: A capture is requested by `latch_ctl` or by `latch_pin`. Either one alone is enough.
- R5: The request is edge-detected. A request held high captures only once. Another capture needs the request to fall and then rise again.
- R6: Between captures, the snapshot does not change. Changes on `in_sync`, `lock_pat` or the received data do not alter it.
- R7: The snapshot is read at address 0x10 (bits 31..24), 0x11 (bits 23..16), 0x12 (bits 15..8) and 0x13 (bits 7..0). Bit 7 of `rd_data` is the most significant bit of each byte.
- R8: A read issued with `rd_en` returns its data on `rd_data` in the following cycle. In any cycle after a cycle with no read, `rd_data` is zero.
- R9: A read of any address other than 0x10 to 0x13 returns zero.
- R10: After reset, the history, the snapshot and `rd_data` are all zero, and the state machine is in `LS_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit | input | 1 | Serial received data |
| rx_en | input | 1 | Marks `rx_bit` as valid in this cycle |
| in_sync | input | 1 | Receiver synchronized flag |
| lock_pat | input | 32 | Pattern that the detector is locked to |
| latch_ctl | input | 1 | Capture request from the control register |
| latch_pin | input | 1 | Capture request from the external pin |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Read data, one cycle after the strobe |

## Verification
The following behaviours are checked by assertions on every cycle:
- the history shift and hold (R1);
- the choice of snapshot source on a request edge (R2, R3);
- snapshot stability between captures (R6);
- zero read data for idle cycles and unmapped addresses (R8, R9).

The bench scenarios show the rest:
- the byte order of the address map (R7);
- that either request source triggers a capture (R4);
- that a long-held request captures only once (R5);
- that a bit arriving in the capture cycle is excluded (R2);
- that injected errors stay out of a locked snapshot (R3);
- the reset contents (R10).

// File: rtl/snap_pkg.sv
package snap_pkg;
    typedef enum logic {
        LS_IDLE = 1'b0,
        LS_HELD = 1'b1
    } latch_state_t;
endpackage

// File: rtl/rx_history.sv
module rx_history #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit,
    input  logic              rx_en,
    output logic [DATA_W-1:0] hist
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (rx_en) begin
            hist <= {hist[DATA_W-2:0], rx_bit};
        end
    end
endmodule

// File: rtl/latch_fsm.sv
module latch_fsm
    import snap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic capture
);
    latch_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and output
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            LS_IDLE: begin
                if (req) begin
                    capture = 1'b1;
                    state_d = LS_HELD;
                end
            end
            LS_HELD: begin
                if (!req) begin
                    state_d = LS_IDLE;
                end
            end
        endcase
    end
endmodule

// File: rtl/snap_regs.sv
module snap_regs #(
    parameter int          DATA_W    = 32,
    parameter int          BYTE_W    = 8,
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  BASE_ADDR = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              in_sync,
    input  logic [DATA_W-1:0] hist,
    input  logic [DATA_W-1:0] lock_pat,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [DATA_W-1:0] snap
);
    localparam int NUM_BYTES = DATA_W / BYTE_W;

    logic [BYTE_W-1:0] sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap <= '0;
        end else if (capture) begin
            snap <= in_sync ? lock_pat : hist;
        end
    end

    // Most significant byte sits at the lowest address
    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (rd_addr == ADDR_W'(int'(BASE_ADDR) + i)) begin
                sel = snap[(NUM_BYTES-1-i)*BYTE_W +: BYTE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_en ? sel : '0;
        end
    end
endmodule

// File: rtl/pattern_snapshot.sv
module pattern_snapshot #(
    parameter int          DATA_W    = 32,
    parameter int          BYTE_W    = 8,
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  BASE_ADDR = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit,
    input  logic              rx_en,
    input  logic              in_sync,
    input  logic [DATA_W-1:0] lock_pat,
    input  logic              latch_ctl,
    input  logic              latch_pin,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    logic [DATA_W-1:0] hist_w;
    logic [DATA_W-1:0] snap_w;
    logic              capture_w;

    rx_history #(.DATA_W(DATA_W)) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_bit (rx_bit),
        .rx_en  (rx_en),
        .hist   (hist_w)
    );

    latch_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (latch_ctl | latch_pin),
        .capture (capture_w)
    );

    snap_regs #(
        .DATA_W    (DATA_W),
        .BYTE_W    (BYTE_W),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture_w),
        .in_sync  (in_sync),
        .hist     (hist_w),
        .lock_pat (lock_pat),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .snap     (snap_w)
    );
endmodule

// File: rtl/snap_chk.sv
module snap_chk #(
    parameter int          DATA_W    = 32,
    parameter int          BYTE_W    = 8,
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  BASE_ADDR = 8'h10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_bit,
    input logic              rx_en,
    input logic              in_sync,
    input logic [DATA_W-1:0] lock_pat,
    input logic              latch_ctl,
    input logic              latch_pin,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [BYTE_W-1:0] rd_data,
    input logic [DATA_W-1:0] hist,
    input logic [DATA_W-1:0] snap
);
    localparam int NUM_BYTES = DATA_W / BYTE_W;

    logic req;
    logic req_q;
    logic rise;
    logic mapped;

    assign req    = latch_ctl | latch_pin;
    assign rise   = req && !req_q;
    assign mapped = (int'(rd_addr) >= int'(BASE_ADDR)) &&
                    (int'(rd_addr) <  int'(BASE_ADDR) + NUM_BYTES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req;
    end

    assert_hist_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en |=> hist == {$past(hist[DATA_W-2:0]), $past(rx_bit)});

    assert_hist_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> $stable(hist));

    assert_capture_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !in_sync) |=> snap == $past(hist));

    assert_capture_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && in_sync) |=> snap == $past(lock_pat));

    assert_snap_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(snap));

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rd_data == '0);

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped) |=> rd_data == '0);
endmodule

bind pattern_snapshot snap_chk #(
    .DATA_W    (DATA_W),
    .BYTE_W    (BYTE_W),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_bit    (rx_bit),
    .rx_en     (rx_en),
    .in_sync   (in_sync),
    .lock_pat  (lock_pat),
    .latch_ctl (latch_ctl),
    .latch_pin (latch_pin),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .hist      (hist_w),
    .snap      (snap_w)
);

// File: tb/tb_pattern_snapshot.sv
`timescale 1ns/1ps
module tb_pattern_snapshot;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_bit = 1'b0;
    logic        rx_en = 1'b0;
    logic        in_sync = 1'b0;
    logic [31:0] lock_pat = '0;
    logic        latch_ctl = 1'b0;
    logic        latch_pin = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Behavioural reference state
    int unsigned m_hist = 0;
    int unsigned m_snap = 0;
    bit          m_req_prev = 1'b0;
    int          m_rd = 0;

    always #5 clk = ~clk;

    pattern_snapshot dut (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_en(rx_en),
        .in_sync(in_sync), .lock_pat(lock_pat), .latch_ctl(latch_ctl),
        .latch_pin(latch_pin), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    function automatic int byte_of(int unsigned w, int a);
        if (a >= 'h10 && a <= 'h13) return int'((w >> (8 * (3 - (a - 'h10)))) & 'hFF);
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hist = 0; m_snap = 0; m_req_prev = 1'b0; m_rd = 0;
        end else begin
            m_rd = rd_en ? byte_of(m_snap, int'(rd_addr)) : 0;
            if ((latch_ctl || latch_pin) && !m_req_prev)
                m_snap = in_sync ? lock_pat : m_hist;
            m_req_prev = latch_ctl || latch_pin;
            if (rx_en) m_hist = (m_hist << 1) | int'(rx_bit);
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // R8: cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) check("R8 model", int'(rd_data), m_rd);
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic send(int unsigned w, int n);
        for (int i = n - 1; i >= 0; i--) begin
            rx_en = 1'b1; rx_bit = w[i]; step();
            rx_en = 1'b0; rx_bit = ~rx_bit;
            if (i % 5 == 0) step();
        end
    endtask

    task automatic rd(int a, int exp, string tag);
        rd_en = 1'b1; rd_addr = 8'(a); step();
        rd_en = 1'b0; rd_addr = 8'h00;
        check(tag, int'(rd_data), exp);
    endtask

    task automatic rd_word(int unsigned w, string tag);
        for (int a = 'h10; a <= 'h13; a++) rd(a, byte_of(w, a), tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R10 reset contents
        rd_word(32'h0, "R10 reset");

        // R1 R2 R7: out-of-sync capture through control bit
        send(32'h5A, 8);
        send(32'hA5C31E77, 32);
        latch_ctl = 1'b1; step(); latch_ctl = 1'b0; step();
        rd_word(32'hA5C31E77, "R2 R7 raw capture");
        rd('h10, 'hA5, "R7 msb byte");
        rd('h13, 'h77, "R1 newest bit at lsb");

        // R2: bit accepted in the capture cycle is excluded
        send(32'hF0F0F0F0, 32);
        rx_en = 1'b1; rx_bit = 1'b1; latch_ctl = 1'b1; step();
        rx_en = 1'b0; latch_ctl = 1'b0; step();
        rd('h13, 'hF0, "R2 same-cycle bit excluded");

        // R3 R4: in-sync capture via pin while errored data arrives
        in_sync = 1'b1; lock_pat = 32'h12345678;
        send(32'hDEADBEEF, 32);
        latch_pin = 1'b1; step(); latch_pin = 1'b0; step();
        rd_word(32'h12345678, "R3 R4 locked capture via pin");

        // R5: held request captures once
        lock_pat = 32'hCAFEF00D;
        latch_pin = 1'b1; step();
        lock_pat = 32'h0BADC0DE;
        latch_ctl = 1'b1;
        for (int i = 0; i < 5; i++) step();
        rd('h10, 'hCA, "R5 held request single capture");
        latch_pin = 1'b0; latch_ctl = 1'b0; step();
        latch_ctl = 1'b1; step(); latch_ctl = 1'b0; step();
        rd('h10, 'h0B, "R5 R4 re-armed capture via control");

        // R6: no request, inputs change, snapshot stays
        in_sync = 1'b0; lock_pat = 32'h11111111;
        send(32'h33333333, 32);
        rd('h13, 'hDE, "R6 snapshot stable");
        in_sync = 1'b1; step();
        rd('h12, 'hC0, "R6 stable after sync change");

        // R9: unmapped addresses
        rd('h0F, 0, "R9 unmapped 0x0F");
        rd('h14, 0, "R9 unmapped 0x14");
        rd('h00, 0, "R9 unmapped 0x00");
        rd('hFF, 0, "R9 unmapped 0xFF");

        // R8: no read gives zero
        step();
        check("R8 idle zero", int'(rd_data), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule